// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received Ethernet frames as a byte stream and lands them in memory buffers. A ring of descriptors in memory describes the buffers. Each descriptor is a run of 16-bit halfwords. Halfword 0 holds the stored frame length. Halfword 1 holds the flags. Halfwords 2 and 3 hold the low and high halves of the buffer pointer. Software prepares descriptors and marks them empty. The engine then takes them in ring order, fills them and hands them back.

For every frame, the engine reads the flags and the buffer pointer of the current descriptor through a halfword memory port with a valid/ready handshake. It then streams the payload into the buffer, one halfword per memory cycle. At the end it writes the length and the updated flags back and moves to the next descriptor. The byte input is held off with a ready signal whenever the memory port is busy. Two interrupt event bits announce each stored frame.

A frame that cannot be stored (receiver disabled, descriptor not empty, too long, or a bad CRC under the discard policy) is consumed without touching the descriptor. A small register-write port sets the ring base, the enable and policy flags, and issues a soft reset and event clears.

Top module: `rx_bd_engine`

## Requirements
- R1: After reset, rx_ready, mem_valid, irq_buf and irq_frame are all low.
- R2: For an accepted frame, the length in bytes is written to halfword 0 (byte address cur+0). The flags halfword (cur+2) is written back with bit 15 (empty) cleared, bit 11 (last) set and every other bit unchanged.
- R3: The payload is packed little-endian: byte 2k goes to bits 7:0 and byte 2k+1 to bits 15:8 of the halfword at buffer pointer + 2k. An odd final byte is written with a zero upper byte.
- R4: Each stored frame sets both irq_buf and irq_frame. A write to register 3 clears irq_buf where data bit 0 is 1 and irq_frame where data bit 1 is 1.
- R5: When the flags of the current descriptor have bit 15 clear, the frame is consumed and dropped. No memory write is made, no event is raised and the ring pointer does not move.
- R6: With control bit 1 clear, the next descriptor follows at the current address + 8.
- R7: With control bit 1 set, the next descriptor follows at the current address + 32.
- R8: When flags bit 13 (wrap) of the stored descriptor is set, the next descriptor is the ring base.
- R9: With control bit 0 (enable) clear, frames are consumed with rx_ready high and no memory access is made.
- R10: With control bit 2 set, a frame whose rx_crc_ok is low at its last byte leaves its descriptor unchanged. With bit 2 clear, such a frame is stored.
- R11: A frame of more than MAX_LEN (8191) bytes leaves its descriptor unchanged. A frame of exactly MAX_LEN bytes is stored.
- R12: A write to register 0 sets the ring base and the ring pointer, with address bits 1:0 forced to zero. The write is ignored while enable is set.
- R13: A write to register 2 with data bit 0 set returns the ring pointer to the base and clears both events.
- R14: A memory request holds mem_valid, mem_we, mem_addr and mem_wdata until mem_ready. rx_ready is never high while mem_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 base, 1 control, 2 soft reset, 3 event clear |
| cfg_wdata | input | AW | Register write data |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_crc_ok | input | 1 | Frame CRC good, sampled with the last byte |
| rx_ready | output | 1 | Engine takes the byte this cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Byte address of the halfword |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory completes the request |
| mem_rdata | input | 16 | Read data, valid with mem_ready on a read |
| irq_buf | output | 1 | Receive-buffer event |
| irq_frame | output | 1 | Receive-frame event |

## Verification
The hardest conditions to reach are the length limit and the ring pointer staying put after a dropped frame. The bench drives a frame of MAX_LEN+1 bytes and then one of exactly MAX_LEN bytes into a descriptor that carries the wrap flag, and checks that the first leaves the length halfword untouched. After a ring walk ends on a descriptor that has not been re-armed, the bench sends a frame into it. It then re-arms that same descriptor and shows that the next frame lands there. A memory model that stalls every other cycle keeps the handshake and the ready hold-off under stress for the whole run.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  localparam int BIT_EMPTY = 15;
  localparam int BIT_WRAP  = 13;
  localparam int BIT_LAST  = 11;

  localparam int BASIC_BYTES = 8;
  localparam int EXT_BYTES   = 32;

  localparam logic [1:0] RA_BASE  = 2'd0;
  localparam logic [1:0] RA_CTRL  = 2'd1;
  localparam logic [1:0] RA_SRST  = 2'd2;
  localparam logic [1:0] RA_EVCLR = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_FLG,
    S_RD_PLO,
    S_RD_PHI,
    S_STREAM,
    S_WR_PAY,
    S_FIN,
    S_WR_LEN,
    S_WR_FLG,
    S_DROP
  } rxbd_state_e;

endpackage

// File: rtl/rxbd_cfg.sv
module rxbd_cfg
  import rxbd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_q,
  output logic          rx_en,
  output logic          ext_mode,
  output logic          drop_crc,
  output logic          base_load,
  output logic [AW-1:0] base_new,
  output logic          soft_rst,
  output logic [1:0]    ev_clr
);

  logic [AW-1:0] base_d;
  logic [2:0]    ctrl_q, ctrl_d;
  logic          ctrl_en;
  logic          unused_hi;

  assign unused_hi = ^cfg_wdata[AW-1:3];

  always_comb begin
    base_new  = {cfg_wdata[AW-1:2], 2'b00};
    base_load = cfg_we && (cfg_addr == RA_BASE) && !ctrl_q[0];
    ctrl_en   = cfg_we && (cfg_addr == RA_CTRL);
    soft_rst  = cfg_we && (cfg_addr == RA_SRST) && cfg_wdata[0];
    ev_clr    = (cfg_we && (cfg_addr == RA_EVCLR)) ? cfg_wdata[1:0] : 2'b00;
    base_d    = base_load ? base_new : base_q;
    ctrl_d    = ctrl_en ? cfg_wdata[2:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (base_load) base_q <= base_d;
      if (ctrl_en)   ctrl_q <= ctrl_d;
    end
  end

  assign rx_en    = ctrl_q[0];
  assign ext_mode = ctrl_q[1];
  assign drop_crc = ctrl_q[2];

endmodule

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr
  import rxbd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_q,
  input  logic          base_load,
  input  logic [AW-1:0] base_new,
  input  logic          soft_rst,
  input  logic          adv,
  input  logic          wrap,
  input  logic          ext_mode,
  output logic [AW-1:0] cur_q
);

  localparam logic [AW-1:0] STEP_BASIC = AW'(BASIC_BYTES);
  localparam logic [AW-1:0] STEP_EXT   = AW'(EXT_BYTES);

  logic [AW-1:0] cur_d;
  logic [AW-1:0] step;
  logic          cur_en;

  always_comb begin
    step   = ext_mode ? STEP_EXT : STEP_BASIC;
    cur_en = base_load || soft_rst || adv;
    cur_d  = cur_q;
    if (base_load)     cur_d = base_new;
    else if (soft_rst) cur_d = base_q;
    else if (adv)      cur_d = wrap ? base_q : (cur_q + step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

endmodule

// File: rtl/rxbd_events.sv
module rxbd_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_set,
  input  logic [1:0] ev_clr,
  input  logic       soft_rst,
  output logic       irq_buf,
  output logic       irq_frame
);

  logic [1:0] ev_q, ev_d;

  always_comb begin
    ev_d = ev_q;
    if (soft_rst) ev_d = 2'b00;
    else          ev_d = ev_q & ~ev_clr;
    if (ev_set)   ev_d = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 2'b00;
    else        ev_q <= ev_d;
  end

  assign irq_buf   = ev_q[0];
  assign irq_frame = ev_q[1];

endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LEN = 8191
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          drop_crc,
  input  logic [AW-1:0] cur,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_ok,
  output logic          rx_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [15:0]   mem_rdata,
  output logic          adv,
  output logic          wrap
);

  localparam int              LEN_W   = $clog2(MAX_LEN + 2);
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_LEN);
  localparam logic [AW-1:0]   OFS_FLG = AW'(2);
  localparam logic [AW-1:0]   OFS_PLO = AW'(4);
  localparam logic [AW-1:0]   OFS_PHI = AW'(6);

  rxbd_state_e      st_q, st_d;
  logic [15:0]      flg_q, flg_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [15:0]      hw_q, hw_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             long_q, long_d, over;
  logic             crc_q, crc_d;
  logic             last_q, last_d;
  logic             wr_need;

  always_comb begin
    cnt_inc = (cnt_q > LEN_LIM) ? cnt_q : (cnt_q + 1'b1);
    over    = cnt_inc > LEN_LIM;
    wr_need = (cnt_q[0] || rx_last) && !over;
  end

  always_comb begin
    st_d      = st_q;
    flg_d     = flg_q;
    ptr_d     = ptr_q;
    hw_d      = hw_q;
    cnt_d     = cnt_q;
    long_d    = long_q;
    crc_d     = crc_q;
    last_d    = last_q;
    rx_ready  = 1'b0;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = 16'h0000;
    adv       = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (rx_valid) begin
          cnt_d  = '0;
          long_d = 1'b0;
          st_d   = rx_en ? S_RD_FLG : S_DROP;
        end
      end
      S_RD_FLG: begin
        mem_valid = 1'b1;
        mem_addr  = cur + OFS_FLG;
        if (mem_ready) begin
          flg_d = mem_rdata;
          st_d  = mem_rdata[BIT_EMPTY] ? S_RD_PLO : S_DROP;
        end
      end
      S_RD_PLO: begin
        mem_valid = 1'b1;
        mem_addr  = cur + OFS_PLO;
        if (mem_ready) begin
          ptr_d = {ptr_q[AW-1:16], mem_rdata};
          st_d  = S_RD_PHI;
        end
      end
      S_RD_PHI: begin
        mem_valid = 1'b1;
        mem_addr  = cur + OFS_PHI;
        if (mem_ready) begin
          ptr_d = {mem_rdata[AW-17:0], ptr_q[15:0]};
          st_d  = S_STREAM;
        end
      end
      S_STREAM: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          cnt_d  = cnt_inc;
          long_d = long_q || over;
          hw_d   = cnt_q[0] ? {rx_data, hw_q[7:0]} : {8'h00, rx_data};
          last_d = rx_last;
          crc_d  = rx_crc_ok;
          if (wr_need)      st_d = S_WR_PAY;
          else if (rx_last) st_d = S_FIN;
        end
      end
      S_WR_PAY: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q;
        mem_wdata = hw_q;
        if (mem_ready) begin
          ptr_d = ptr_q + AW'(2);
          st_d  = last_q ? S_FIN : S_STREAM;
        end
      end
      S_FIN: begin
        st_d = (long_q || (drop_crc && !crc_q)) ? S_IDLE : S_WR_LEN;
      end
      S_WR_LEN: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur;
        mem_wdata = 16'(cnt_q);
        if (mem_ready) st_d = S_WR_FLG;
      end
      S_WR_FLG: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + OFS_FLG;
        mem_wdata = flg_q;
        mem_wdata[BIT_EMPTY] = 1'b0;
        mem_wdata[BIT_LAST]  = 1'b1;
        if (mem_ready) begin
          adv  = 1'b1;
          st_d = S_IDLE;
        end
      end
      S_DROP: begin
        rx_ready = 1'b1;
        if (rx_valid && rx_last) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign wrap = flg_q[BIT_WRAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      flg_q  <= '0;
      ptr_q  <= '0;
      hw_q   <= '0;
      cnt_q  <= '0;
      long_q <= 1'b0;
      crc_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flg_q  <= flg_d;
      ptr_q  <= ptr_d;
      hw_q   <= hw_d;
      cnt_q  <= cnt_d;
      long_q <= long_d;
      crc_q  <= crc_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/rx_bd_engine.sv
module rx_bd_engine #(
  parameter int AW      = 32,
  parameter int MAX_LEN = 8191
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_ok,
  output logic          rx_ready,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [15:0]   mem_rdata,
  output logic          irq_buf,
  output logic          irq_frame
);

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic [AW-1:0] base_q, base_new, cur_q;
  logic          rx_en, ext_mode, drop_crc;
  logic          base_load, soft_rst;
  logic [1:0]    ev_clr;
  logic          ring_adv, ring_wrap;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rxbd_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_core_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .base_q(base_q), .rx_en(rx_en), .ext_mode(ext_mode), .drop_crc(drop_crc),
    .base_load(base_load), .base_new(base_new), .soft_rst(soft_rst), .ev_clr(ev_clr)
  );

  rxbd_ring_ptr #(.AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_core_n),
    .base_q(base_q), .base_load(base_load), .base_new(base_new),
    .soft_rst(soft_rst), .adv(ring_adv), .wrap(ring_wrap),
    .ext_mode(ext_mode), .cur_q(cur_q)
  );

  rxbd_ctrl #(.AW(AW), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .rx_en(rx_en), .drop_crc(drop_crc), .cur(cur_q),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_crc_ok(rx_crc_ok), .rx_ready(rx_ready),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .adv(ring_adv), .wrap(ring_wrap)
  );

  rxbd_events u_ev (
    .clk(clk), .rst_n(rst_core_n),
    .ev_set(ring_adv), .ev_clr(ev_clr), .soft_rst(soft_rst),
    .irq_buf(irq_buf), .irq_frame(irq_frame)
  );

endmodule

// File: rtl/rxbd_chk.sv
module rxbd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          rx_ready,
  input logic          irq_buf,
  input logic          irq_frame,
  input logic          ring_adv
);

  assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

  assert_no_overlap_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && mem_valid));

  assert_flag_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ring_adv |-> (mem_valid && mem_ready && mem_we && !mem_wdata[15] && mem_wdata[11]));

  assert_events_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ring_adv |=> (irq_buf && irq_frame));

  assert_event_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_buf) |-> $past(ring_adv));

endmodule

bind rx_bd_engine rxbd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_ready(rx_ready),
  .irq_buf(irq_buf), .irq_frame(irq_frame), .ring_adv(ring_adv)
);

// File: tb/tb_rx_bd_engine.sv
module tb_rx_bd_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'd0;
  logic        rx_last = 1'b0;
  logic        rx_crc_ok = 1'b1;
  logic        rx_ready;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        irq_buf, irq_frame;

  logic [15:0] mem [0:4095];
  logic        stall_q = 1'b0;
  int          txn_cnt = 0;
  int          wr_cnt = 0;
  int          vectors = 0;
  int          miscompares = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  rx_bd_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_ok(rx_crc_ok),
    .rx_ready(rx_ready), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .irq_buf(irq_buf), .irq_frame(irq_frame)
  );

  // memory model: 8 KB, ready on every other cycle, writes above the window dropped
  assign mem_ready = mem_valid && stall_q;
  assign mem_rdata = (mem_addr < 32'h2000) ? mem[mem_addr[12:1]] : 16'h0000;

  always @(negedge clk) stall_q <= ~stall_q;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      txn_cnt <= txn_cnt + 1;
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        if (mem_addr < 32'h2000) mem[mem_addr[12:1]] <= mem_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [31:0] a);
    return mem[a[12:1]];
  endfunction

  task automatic set_desc(input logic [31:0] a, input logic [15:0] len,
                          input logic [15:0] flg, input logic [31:0] ptr);
    mem[a[12:1]]        = len;
    mem[a[12:1] + 12'd1] = flg;
    mem[a[12:1] + 12'd2] = ptr[15:0];
    mem[a[12:1] + 12'd3] = ptr[31:16];
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return seed + 8'(3 * i);
  endfunction

  task automatic send_frame(input int n, input logic [7:0] seed, input logic crc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pbyte(seed, i); rx_last = (i == n - 1); rx_crc_ok = crc;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd0);
    chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R1 irq_buf", {31'd0, irq_buf}, 32'd0);
    chk("R1 irq_frame", {31'd0, irq_frame}, 32'd0);
  endtask

  task automatic t_accept();
    set_desc(32'h100, 16'h0, 16'h8004, 32'h0800);
    set_desc(32'h108, 16'h0, 16'h8000, 32'h0900);
    set_desc(32'h110, 16'h0, 16'hA000, 32'h0A00);
    cfg_write(2'd0, 32'h103);            // R12 low bits forced to zero
    cfg_write(2'd1, 32'h1);
    send_frame(5, 8'h10, 1'b1);
    chk("R2 length", {16'd0, rd(32'h100)}, 32'd5);
    chk("R2 flags", {16'd0, rd(32'h102)}, 32'h0804);
    chk("R3 hw0", {16'd0, rd(32'h800)}, {16'd0, pbyte(8'h10, 1), pbyte(8'h10, 0)});
    chk("R3 hw1", {16'd0, rd(32'h802)}, {16'd0, pbyte(8'h10, 3), pbyte(8'h10, 2)});
    chk("R3 odd tail", {16'd0, rd(32'h804)}, {24'd0, pbyte(8'h10, 4)});
    chk("R4 both set", {30'd0, irq_frame, irq_buf}, 32'd3);
    cfg_write(2'd3, 32'h1);
    chk("R4 clear buf", {30'd0, irq_frame, irq_buf}, 32'd2);
    cfg_write(2'd3, 32'h2);
    chk("R4 clear frame", {30'd0, irq_frame, irq_buf}, 32'd0);
  endtask

  task automatic t_advance_wrap();
    send_frame(4, 8'h40, 1'b1);
    chk("R6 next at +8 len", {16'd0, rd(32'h108)}, 32'd4);
    chk("R6 next at +8 flags", {16'd0, rd(32'h10A)}, 32'h0800);
    send_frame(3, 8'h50, 1'b1);
    chk("R8 wrap desc len", {16'd0, rd(32'h110)}, 32'd3);
    chk("R8 wrap desc flags", {16'd0, rd(32'h112)}, 32'h2800);
  endtask

  task automatic t_overflow();
    int w0;
    cfg_write(2'd3, 32'h3);
    w0 = wr_cnt;
    send_frame(6, 8'h60, 1'b1);          // base descriptor still owned by software
    chk("R5 no writes", 32'(wr_cnt - w0), 32'd0);
    chk("R5 length kept", {16'd0, rd(32'h100)}, 32'd5);
    chk("R5 no event", {30'd0, irq_frame, irq_buf}, 32'd0);
    mem[12'h080 + 12'd1] = 16'h8000;     // re-arm base descriptor
    send_frame(2, 8'h70, 1'b1);
    chk("R8 ring back at base / R5 pointer held", {16'd0, rd(32'h100)}, 32'd2);
  endtask

  task automatic t_base_softrst();
    cfg_write(2'd0, 32'h600);            // enabled: must be ignored
    mem[12'h084 + 12'd1] = 16'h8000;
    send_frame(7, 8'h80, 1'b1);
    chk("R12 write ignored while enabled", {16'd0, rd(32'h108)}, 32'd7);
    chk("R12 no access at new base", {16'd0, rd(32'h602)}, 32'd0);
    chk("R4 set before soft reset", {30'd0, irq_frame, irq_buf}, 32'd3);
    cfg_write(2'd2, 32'h1);
    chk("R13 events cleared", {30'd0, irq_frame, irq_buf}, 32'd0);
    mem[12'h080 + 12'd1] = 16'h8000;
    send_frame(1, 8'h90, 1'b1);
    chk("R13 pointer back at base", {16'd0, rd(32'h100)}, 32'd1);
    chk("R3 single byte", {16'd0, rd(32'h800)}, {24'd0, pbyte(8'h90, 0)});
  endtask

  task automatic t_disabled_ext();
    int t0;
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd3, 32'h3);
    t0 = txn_cnt;
    send_frame(4, 8'hA0, 1'b1);
    chk("R9 no memory access", 32'(txn_cnt - t0), 32'd0);
    chk("R9 no event", {30'd0, irq_frame, irq_buf}, 32'd0);
    set_desc(32'h200, 16'h0, 16'h8000, 32'h0C00);
    set_desc(32'h220, 16'h0, 16'hA000, 32'h0D00);
    cfg_write(2'd0, 32'h200);
    cfg_write(2'd1, 32'h3);
    send_frame(2, 8'hB0, 1'b1);
    chk("R12 base taken when disabled", {16'd0, rd(32'h200)}, 32'd2);
    send_frame(2, 8'hB4, 1'b1);
    chk("R7 next at +32", {16'd0, rd(32'h220)}, 32'd2);
  endtask

  task automatic t_crc();
    set_desc(32'h200, 16'h1234, 16'h8000, 32'h0C00);
    cfg_write(2'd1, 32'h7);
    send_frame(3, 8'hC0, 1'b0);
    chk("R10 bad CRC len kept", {16'd0, rd(32'h200)}, 32'h1234);
    chk("R10 bad CRC flags kept", {16'd0, rd(32'h202)}, 32'h8000);
    cfg_write(2'd1, 32'h3);
    send_frame(3, 8'hC8, 1'b0);
    chk("R10 stored without discard", {16'd0, rd(32'h200)}, 32'd3);
  endtask

  task automatic t_long();
    set_desc(32'h220, 16'hBEEF, 16'hA000, 32'h1000);
    send_frame(8192, 8'h01, 1'b1);
    chk("R11 over-length len kept", {16'd0, rd(32'h220)}, 32'h0000BEEF);
    chk("R11 over-length flags kept", {16'd0, rd(32'h222)}, 32'h0000A000);
    send_frame(8191, 8'h02, 1'b1);
    chk("R11 max length stored", {16'd0, rd(32'h220)}, 32'd8191);
    chk("R11 max length flags", {16'd0, rd(32'h222)}, 32'h2800);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_accept();
    t_advance_wrap();
    t_overflow();
    t_base_softrst();
    t_disabled_ext();
    t_crc();
    t_long();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule